// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Controller

This block turns single requests from an internal master into cycles on an external asynchronous bus that serves memories and peripherals. A request carries an address, right-justified write data, a direction and an access size (byte, halfword or word). The block compares the address with six programmable windows. It then asserts one active-low select and runs a one-clock address phase, followed by a data phase that is stretched by a per-window wait count. At the end it returns the captured read data, or simply an acknowledge for a write, on a one-cycle response strobe.

The 32-bit pin group can work in two ways. In shared mode it carries the address in the address phase and data in the data phase. During the data phase, the lanes that a narrow port does not use keep carrying the address. In split mode the pin group carries data only, and the address goes out on its own output. A 3-bit strap chooses between the two modes. It is sampled while reset is held and is ignored after that. Between cycles, no lane of the pin group is driven.

Top module: `extbus_ctrl`

## Requirements
- R1: Window i matches when its valid bit is set and (address[31:16] AND mask_i) equals (base_i AND mask_i). The matched select is driven low for the whole cycle and all other selects stay high.
- R2: When several windows match, only the lowest-numbered one is selected.
- R3: A request that matches no window is accepted and answered on the next clock with rsp_valid and rsp_err both high. No select, byte strobe or output enable goes low, and no lane is driven.
- R4: A request is accepted on a clock edge where req_valid and req_ready are both high. After that edge the address phase lasts one clock and the data phase lasts wait+1 clocks. rsp_valid is high for exactly the one clock after the last data clock, with rsp_err low. req_ready is high only when no cycle is running.
- R5: In shared mode, the address phase drives the full 32-bit address on bus_ad_o, with all four lane enables high.
- R6: In shared mode, the data phase keeps the address on the lanes outside the port. For a 16-bit port these are bits 15:0, and for an 8-bit port bits 23:0. Those lanes stay enabled for both reads and writes.
- R7: In split mode, bus_addr_o holds the address for the whole cycle. No lane is driven in the address phase, and lanes outside the port are never driven.
- R8: Split mode is selected only if mode_strap equals 3'b011 while rst_n is low. Any other value selects shared mode. Changing the strap after reset has no effect.
- R9: All lane enables bus_ad_oe are low whenever no cycle is running.
- R10: Lane k covers bus bits 8k+7:8k, and bus_be_n[k] covers lane k. Port size code 00 = 32-bit (lanes 3..0), 01 = 8-bit (lane 3), 10 = 16-bit (lanes 3..2). Size code 00 = byte, 01 = halfword, 10 = word. Within the port, byte offset o = (address mod port bytes), rounded down to the access size, sits on lane 3-o. In the data phase, bus_be_n is low only on the lanes the access uses.
- R11: If a window's write-only strobe bit is 1, bus_be_n stays high during reads to it. If the bit is 0, strobes assert on reads and on writes.
- R12: bus_oe_n is low only in the data phase of a read to a matched window.
- R13: Write data is shifted onto the used lanes, and the port's other lanes carry zero. Read data is taken from the used lanes at the last data clock and returned right-justified, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_strap | input | 3 | Mode strap, sampled during reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_addr | input | 32 | Transfer address |
| req_wdata | input | 32 | Right-justified write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| rsp_valid | output | 1 | One-clock completion strobe |
| rsp_err | output | 1 | No window matched |
| rsp_rdata | output | 32 | Right-justified read data |
| cfg_base | input | 96 | Six 16-bit window bases, window 0 lowest |
| cfg_mask | input | 96 | Six 16-bit window masks |
| cfg_valid | input | 6 | Window enables |
| cfg_psize | input | 12 | Port size code per window |
| cfg_bwe_only | input | 6 | Strobes on writes only, per window |
| cfg_wait | input | 24 | 4-bit wait count per window |
| bus_ad_o | output | 32 | Address/data pins, output value |
| bus_ad_oe | output | 4 | Per-lane drive enable |
| bus_ad_i | input | 32 | Address/data pins, input value |
| bus_addr_o | output | 32 | Address output, held during a cycle |
| bus_cs_n | output | 6 | Active-low selects |
| bus_be_n | output | 4 | Active-low byte strobes |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_rnw | output | 1 | High for read or idle, low for write |

## Verification
Random requests are spread over four windows with different port widths, wait counts and strobe options, and over two unmapped regions. Each request uses a random legal size and offset, so lane placement, address retention on free lanes and stretch length are checked for every port and size combination. The read input changes on every data clock, which shows whether capture happens on the last data clock or an earlier one. Overlapping windows separate a correct priority order from a reversed one. The same stream is run after a reset with each strap value, and the strap is changed after reset, so that shared mode and split mode are both exercised and an unlatched strap would show up.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ADDR = 2'd1, ST_DATA = 2'd2} bus_state_t;

  // Lanes belonging to a port of the given size code
  function automatic logic [3:0] port_lanes(input logic [1:0] ps);
    case (ps)
      2'b01:   return 4'b1000;
      2'b10:   return 4'b1100;
      default: return 4'b1111;
    endcase
  endfunction

  // Lowest lane used by an access
  function automatic logic [1:0] lane_low(input logic [1:0] ps, input logic [1:0] sz,
                                          input logic [1:0] a);
    logic [2:0] off;
    logic [2:0] nb;
    nb = (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;
    case (ps)
      2'b01:   off = 3'd0;
      2'b10:   off = (sz == 2'd0) ? {2'b00, a[0]} : 3'd0;
      default: off = (sz == 2'd0) ? {1'b0, a} : (sz == 2'd1) ? {1'b0, a[1], 1'b0} : 3'd0;
    endcase
    return 2'(3'd4 - off - nb);
  endfunction

  function automatic logic [3:0] lane_used(input logic [1:0] ps, input logic [1:0] sz,
                                           input logic [1:0] a);
    logic [1:0] lo;
    lo = lane_low(ps, sz, a);
    case (sz)
      2'd0:    return 4'b0001 << lo;
      2'd1:    return 4'b0011 << lo;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_bits(input logic [3:0] l);
    return {{8{l[3]}}, {8{l[2]}}, {8{l[1]}}, {8{l[0]}}};
  endfunction

  function automatic logic [DATA_W-1:0] size_bits(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/extbus_decode.sv
module extbus_decode #(
  parameter int NUM_CS = 6,
  parameter int CMP_W  = 16,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [CMP_W-1:0]        addr_hi,
  input  logic [NUM_CS*CMP_W-1:0] base,
  input  logic [NUM_CS*CMP_W-1:0] mask,
  input  logic [NUM_CS-1:0]       valid,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx,
  output logic [NUM_CS-1:0]       match
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_win
    logic [CMP_W-1:0] m;
    assign m        = mask[i*CMP_W +: CMP_W];
    assign match[i] = valid[i] && ((addr_hi & m) == (base[i*CMP_W +: CMP_W] & m));
  end

  // lowest index wins: scan downward so the last assignment is the lowest match
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    a_hit_any_r1 : assert (hit == (|match));
  end

endmodule

// File: rtl/extbus_lanes.sv
module extbus_lanes
  import extbus_pkg::*;
(
  input  logic              split_mode,
  input  logic              in_addr,
  input  logic              in_data,
  input  logic              wr,
  input  logic [1:0]        ps,
  input  logic [1:0]        sz,
  input  logic [31:0]       addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] ad_o,
  output logic [LANES-1:0]  ad_oe,
  output logic [LANES-1:0]  used,
  output logic [DATA_W-1:0] rdata_next
);

  logic [3:0]        pl;
  logic [1:0]        lo;
  logic [DATA_W-1:0] port_b;
  logic [DATA_W-1:0] wshift;

  assign pl     = port_lanes(ps);
  assign lo     = lane_low(ps, sz, addr[1:0]);
  assign used   = lane_used(ps, sz, addr[1:0]);
  assign port_b = lane_bits(pl);
  assign wshift = (wdata & size_bits(sz)) << {lo, 3'b000};

  always_comb begin
    ad_o  = '0;
    ad_oe = '0;
    if (in_addr) begin
      ad_o  = split_mode ? '0 : addr;
      ad_oe = split_mode ? 4'b0000 : 4'b1111;
    end else if (in_data) begin
      ad_o  = (wr ? (wshift & port_b) : '0) | (split_mode ? '0 : (addr & ~port_b));
      ad_oe = (wr ? pl : 4'b0000) | (split_mode ? 4'b0000 : ~pl);
    end
  end

  assign rdata_next = (bus_in >> {lo, 3'b000}) & size_bits(sz);

  always_comb begin
    a_used_in_port_r10 : assert ((used & ~pl) == 4'b0000 || !in_data);
  end

endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int CMP_W  = 16,
  parameter int WAIT_W = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               mode_strap,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [31:0]              req_addr,
  input  logic [31:0]              req_wdata,
  input  logic                     req_write,
  input  logic [1:0]               req_size,
  output logic                     rsp_valid,
  output logic                     rsp_err,
  output logic [31:0]              rsp_rdata,
  input  logic [NUM_CS*CMP_W-1:0]  cfg_base,
  input  logic [NUM_CS*CMP_W-1:0]  cfg_mask,
  input  logic [NUM_CS-1:0]        cfg_valid,
  input  logic [NUM_CS*2-1:0]      cfg_psize,
  input  logic [NUM_CS-1:0]        cfg_bwe_only,
  input  logic [NUM_CS*WAIT_W-1:0] cfg_wait,
  output logic [31:0]              bus_ad_o,
  output logic [3:0]               bus_ad_oe,
  input  logic [31:0]              bus_ad_i,
  output logic [31:0]              bus_addr_o,
  output logic [NUM_CS-1:0]        bus_cs_n,
  output logic [3:0]               bus_be_n,
  output logic                     bus_oe_n,
  output logic                     bus_rnw
);

  localparam logic [2:0] SPLIT_STRAP = 3'b011;

  bus_state_t        state_q;
  logic              split_q;
  logic [31:0]       addr_q;
  logic [31:0]       wdata_q;
  logic              wr_q;
  logic [1:0]        size_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              rsp_valid_q;
  logic              rsp_err_q;
  logic [31:0]       rdata_q;

  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [NUM_CS-1:0] match;
  logic [1:0]        ps_sel;
  logic              bwe_sel;
  logic [3:0]        used;
  logic [31:0]       rdata_next;

  // named events for the checks
  logic busy, in_addr, in_data, accept_evt, miss_evt, last_evt;

  assign busy       = (state_q != ST_IDLE);
  assign in_addr    = (state_q == ST_ADDR);
  assign in_data    = (state_q == ST_DATA);
  assign accept_evt = (state_q == ST_IDLE) && req_valid;
  assign miss_evt   = accept_evt && !hit;
  assign last_evt   = in_data && (cnt_q == '0);

  extbus_decode #(.NUM_CS(NUM_CS), .CMP_W(CMP_W)) u_dec (
    .addr_hi (req_addr[31 -: CMP_W]),
    .base    (cfg_base),
    .mask    (cfg_mask),
    .valid   (cfg_valid),
    .hit     (hit),
    .idx     (hit_idx),
    .match   (match)
  );

  assign ps_sel  = cfg_psize[idx_q*2 +: 2];
  assign bwe_sel = cfg_bwe_only[idx_q];

  extbus_lanes u_lanes (
    .split_mode (split_q),
    .in_addr    (in_addr),
    .in_data    (in_data),
    .wr         (wr_q),
    .ps         (ps_sel),
    .sz         (size_q),
    .addr       (addr_q),
    .wdata      (wdata_q),
    .bus_in     (bus_ad_i),
    .ad_o       (bus_ad_o),
    .ad_oe      (bus_ad_oe),
    .used       (used),
    .rdata_next (rdata_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      split_q     <= (mode_strap == SPLIT_STRAP);
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      wr_q        <= 1'b0;
      size_q      <= '0;
      idx_q       <= '0;
      cnt_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          size_q  <= req_size;
          if (hit) begin
            idx_q   <= hit_idx;
            cnt_q   <= cfg_wait[hit_idx*WAIT_W +: WAIT_W];
            state_q <= ST_ADDR;
          end else begin
            rsp_valid_q <= 1'b1;
            rsp_err_q   <= 1'b1;
          end
        end
        ST_ADDR: state_q <= ST_DATA;
        ST_DATA: begin
          if (cnt_q == '0) begin
            rsp_valid_q <= 1'b1;
            if (!wr_q) rdata_q <= rdata_next;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = !busy;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_err    = rsp_err_q;
  assign rsp_rdata  = rdata_q;
  assign bus_addr_o = busy ? addr_q : '0;
  assign bus_cs_n   = busy ? ~(NUM_CS'(1) << idx_q) : '1;
  assign bus_oe_n   = !(in_data && !wr_q);
  assign bus_be_n   = (in_data && (wr_q || !bwe_sel)) ? ~used : 4'hF;
  assign bus_rnw    = !(busy && wr_q);

  p_one_cs_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  p_miss_quiet_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (&bus_cs_n) && rsp_valid && rsp_err && (bus_ad_oe == 4'h0));
  p_addr_one_clk_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    in_addr |=> in_data);
  p_rsp_after_last_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> rsp_valid && !rsp_err && req_ready);
  p_strap_held_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    $stable(split_q));
  p_idle_float_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_ad_oe == 4'h0));
  p_write_only_strobe_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_q && bwe_sel) |-> (&bus_be_n));
  p_oe_read_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> (bus_rnw && !(&bus_cs_n)));

endmodule

// File: tb/tb_extbus_ctrl.sv
`timescale 1ns/1ps
module tb_extbus_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_strap = 3'b000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [95:0] cfg_base, cfg_mask;
  logic [5:0]  cfg_valid, cfg_bwe_only;
  logic [11:0] cfg_psize;
  logic [23:0] cfg_wait;
  logic [31:0] bus_ad_o, bus_ad_i = '0, bus_addr_o;
  logic [3:0]  bus_ad_oe, bus_be_n;
  logic [5:0]  bus_cs_n;
  logic        bus_oe_n, bus_rnw;

  int n_tests = 0;
  int n_fail  = 0;

  // window setup: base, mask, valid, port code, write-only strobes, wait
  logic [15:0] w_base [6] = '{16'h1000, 16'h2000, 16'h3000, 16'h1000, 16'h4000, 16'h5000};
  logic [15:0] w_mask [6] = '{16'hF000, 16'hF000, 16'hF000, 16'hFF00, 16'hF000, 16'hF000};
  bit          w_val  [6] = '{1, 1, 1, 1, 0, 1};
  logic [1:0]  w_ps   [6] = '{2'b00, 2'b10, 2'b01, 2'b00, 2'b00, 2'b10};
  bit          w_bwe  [6] = '{0, 1, 1, 0, 0, 0};
  int          w_wait [6] = '{0, 2, 1, 3, 0, 15};

  always #2.5 clk = ~clk;

  extbus_ctrl dut (.*);

  initial begin
    for (int i = 0; i < 6; i++) begin
      cfg_base[i*16 +: 16] = w_base[i];
      cfg_mask[i*16 +: 16] = w_mask[i];
      cfg_valid[i]         = w_val[i];
      cfg_psize[i*2 +: 2]  = w_ps[i];
      cfg_bwe_only[i]      = w_bwe[i];
      cfg_wait[i*4 +: 4]   = 4'(w_wait[i]);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_cs(input logic [31:0] a);
    for (int i = 0; i < 6; i++)
      if (w_val[i] && ((a[31:16] ^ w_base[i]) & w_mask[i]) == 16'h0) return i;
    return -1;
  endfunction

  function automatic int port_bytes(input logic [1:0] ps);
    return (ps == 2'b01) ? 1 : (ps == 2'b10) ? 2 : 4;
  endfunction

  // byte offset inside the port, aligned to the access size
  function automatic int exp_off(input logic [1:0] ps, input logic [1:0] sz, input logic [31:0] a);
    int nb = 1 << sz;
    return ((int'(a) % port_bytes(ps)) / nb) * nb;
  endfunction

  function automatic logic [3:0] exp_used(input logic [1:0] ps, input logic [1:0] sz, input logic [31:0] a);
    logic [3:0] m = '0;
    for (int k = 0; k < (1 << sz); k++) m[3 - exp_off(ps, sz, a) - k] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] bytes_of(input logic [3:0] l);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) if (l[k]) r[k*8 +: 8] = 8'hFF;
    return r;
  endfunction

  function automatic logic [3:0] exp_port(input logic [1:0] ps);
    return (ps == 2'b01) ? 4'b1000 : (ps == 2'b10) ? 4'b1100 : 4'b1111;
  endfunction

  task automatic do_reset(input logic [2:0] strap, input logic [2:0] later);
    @(negedge clk);
    rst_n = 1'b0; mode_strap = strap; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mode_strap = later;
    chk(req_ready && !rsp_valid, "R4 reset ready", {30'b0, req_ready, rsp_valid}, 32'h2);
    chk(bus_cs_n == 6'h3F && bus_be_n == 4'hF && bus_oe_n, "R12 reset strobes",
        {22'b0, bus_cs_n, bus_be_n}, {22'b0, 6'h3F, 4'hF});
    chk(bus_ad_oe == 4'h0, "R9 reset lanes", {28'b0, bus_ad_oe}, 32'h0);
  endtask

  task automatic do_txn(input logic [31:0] a, input logic [31:0] wd, input bit wr,
                        input logic [1:0] sz, input bit split);
    int          cs = exp_cs(a);
    logic [1:0]  ps;
    logic [3:0]  pl, used, oe_exp, be_exp;
    logic [31:0] pb, wshift, ad_exp, rd_last, rd_exp;
    int          lo;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_wdata = wd; req_write = wr; req_size = sz;
    chk(req_ready, "R4 ready idle", {31'b0, req_ready}, 32'h1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (cs < 0) begin
      chk(rsp_valid && rsp_err, "R3 miss response", {30'b0, rsp_valid, rsp_err}, 32'h3);
      chk(bus_cs_n == 6'h3F && bus_be_n == 4'hF && bus_oe_n && bus_ad_oe == 4'h0,
          "R3 miss quiet", {17'b0, bus_cs_n, bus_be_n, bus_oe_n, bus_ad_oe}, {17'b0, 6'h3F, 4'hF, 1'b1, 4'h0});
      return;
    end
    ps   = w_ps[cs];
    pl   = exp_port(ps);
    pb   = bytes_of(pl);
    used = exp_used(ps, sz, a);
    lo   = 4 - exp_off(ps, sz, a) - (1 << sz);
    wshift = (wd & bytes_of(4'((1 << (1 << sz)) - 1))) << (8 * lo);
    // address phase
    chk(bus_cs_n == ~(6'd1 << cs), (cs == 0 && a[31:24] == 8'h10) ? "R2 priority" : "R1 select",
        {26'b0, bus_cs_n}, {26'b0, ~(6'd1 << cs)});
    chk(bus_ad_oe == (split ? 4'h0 : 4'hF), "R8 mode at address phase", {28'b0, bus_ad_oe}, {28'b0, split ? 4'h0 : 4'hF});
    if (!split) chk(bus_ad_o == a, "R5 address on bus", bus_ad_o, a);
    else        chk(bus_addr_o == a, "R7 split address", bus_addr_o, a);
    chk(bus_be_n == 4'hF && bus_oe_n, "R12 quiet in address phase", {27'b0, bus_be_n, bus_oe_n}, 32'h1F);
    // data phase
    rd_last = '0;
    for (int d = 0; d <= w_wait[cs]; d++) begin
      @(posedge clk);
      @(negedge clk);
      rd_last  = $urandom;
      bus_ad_i = rd_last;
      chk(!rsp_valid && bus_cs_n == ~(6'd1 << cs), "R4 data phase held",
          {25'b0, rsp_valid, bus_cs_n}, {25'b0, 1'b0, ~(6'd1 << cs)});
      be_exp = (wr || !w_bwe[cs]) ? ~used : 4'hF;
      chk(bus_be_n == be_exp, (!wr && w_bwe[cs]) ? "R11 write-only strobes" : "R10 byte strobes",
          {28'b0, bus_be_n}, {28'b0, be_exp});
      chk(bus_oe_n == wr, "R12 output enable", {31'b0, bus_oe_n}, {31'b0, wr});
      oe_exp = (wr ? pl : 4'h0) | (split ? 4'h0 : ~pl);
      chk(bus_ad_oe == oe_exp, split ? "R7 lane enables" : "R6 lane enables", {28'b0, bus_ad_oe}, {28'b0, oe_exp});
      ad_exp = (wr ? (wshift & pb) : '0) | (split ? '0 : (a & ~pb));
      chk((bus_ad_o & bytes_of(oe_exp)) == ad_exp, wr ? "R13 write lanes" : "R6 free lanes",
          bus_ad_o & bytes_of(oe_exp), ad_exp);
      if (split) chk(bus_addr_o == a, "R7 split address held", bus_addr_o, a);
    end
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid && !rsp_err, "R4 response", {30'b0, rsp_valid, rsp_err}, 32'h2);
    chk(bus_ad_oe == 4'h0 && bus_cs_n == 6'h3F, "R9 released", {22'b0, bus_cs_n, bus_ad_oe}, {22'b0, 6'h3F, 4'h0});
    if (!wr) begin
      rd_exp = (rd_last >> (8 * lo)) & bytes_of(4'((1 << (1 << sz)) - 1));
      chk(rsp_rdata == rd_exp, "R13 read data", rsp_rdata, rd_exp);
    end
  endtask

  task automatic rand_txn(input bit split);
    logic [3:0]  nib [6] = '{4'h1, 4'h2, 4'h3, 4'h5, 4'h4, 4'h9};
    logic [31:0] a = {nib[$urandom % 6], 28'($urandom)};
    int          cs = exp_cs(a);
    int          maxsz = (cs < 0) ? 2 : (w_ps[cs] == 2'b01) ? 0 : (w_ps[cs] == 2'b10) ? 1 : 2;
    do_txn(a, $urandom, 1'($urandom), 2'($urandom % (maxsz + 1)), split);
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset(3'b000, 3'b011);
    do_txn(32'h10AB_0001, 32'h0, 1'b0, 2'd0, 1'b0);     // R2 overlap, byte read lane 2
    do_txn(32'h2000_0003, 32'h0000_00A5, 1'b1, 2'd0, 1'b0); // R6 16-bit port byte write
    do_txn(32'h3000_1234, 32'h0, 1'b0, 2'd0, 1'b0);     // R11 8-bit read, no strobes
    do_txn(32'h4000_0000, 32'h0, 1'b0, 2'd2, 1'b0);     // R3 invalid window
    do_txn(32'h5000_0002, 32'h0000_BEEF, 1'b1, 2'd1, 1'b0); // R4 longest stretch
    for (int i = 0; i < 60; i++) rand_txn(1'b0);
    do_reset(3'b011, 3'b000);
    do_txn(32'h1000_0002, 32'h0000_1234, 1'b1, 2'd1, 1'b1);
    do_txn(32'h3000_0000, 32'h0, 1'b0, 2'd0, 1'b1);
    do_txn(32'h9000_0000, 32'h0, 1'b1, 2'd0, 1'b1);     // R3 unmapped
    for (int i = 0; i < 60; i++) rand_txn(1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule